// File: doc/BRIEF.md
# Attribute Index Divider Unit

This unit turns a 32-bit linear thread index into the element index of one attribute stream. Each request carries a mode that selects the mapping. The index may pass straight through. It may be reduced modulo a divisor of the form odd·2^n, where the odd factor is 1, 3, 5, 7 or 9. It may be shifted right by a power of two. It may be divided by an arbitrary constant through a precomputed reciprocal multiplier with an optional round-down correction. Software or a setup stage computes the constants. The unit only applies them.

Requests enter with a valid strobe and leave exactly two clock cycles later with their own valid strobe. A new request is accepted on every cycle, so a stream of thread indices flows through without stalls. Turning the element index into an address is done downstream.

Top module: `attr_index_divider`

## Requirements
- R1: With mode code 0 (pass), the output index equals the input index.
- R2: With mode code 1 (modulo), the output equals index mod (F·2^shift), where F = 2·flags+1 for a flags value from 0 to 4, and F = 1 for a flags value from 5 to 7.
- R3: In modulo mode the output index is always below F·2^shift, and its low `shift` bits equal those of the input index.
- R4: With mode code 2 (shift), the output equals the input index shifted right logically by the 5-bit shift field (0 to 31).
- R5: With mode code 3 (magic), bit 31 of the multiplier field is treated as one whatever value is supplied.
- R6: In magic mode, the output is the upper 32 bits of the 64-bit product of index and multiplier, shifted right by the shift field. The index is not shifted before the multiply.
- R7: In magic mode with a flags value of exactly 1, the index is first incremented by one, saturating at 0xFFFFFFFF, before the multiply. Any other flags value applies no increment.
- R8: A request presented with in_valid high at a clock edge appears at the outputs with out_valid high after the second following edge. Back-to-back requests are accepted every cycle, and out_valid is low two cycles after a cycle with in_valid low.
- R9: While rst_n is low, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_index | input | 32 | Linear thread index |
| in_mode | input | 2 | 0 pass, 1 modulo, 2 shift, 3 magic divide |
| in_shift | input | 5 | Power-of-two exponent or post-shift |
| in_magic | input | 32 | Reciprocal multiplier, bit 31 ignored |
| in_flags | input | 3 | Odd-factor selector (modulo) or round-down enable (magic) |
| out_valid | output | 1 | Result strobe |
| out_index | output | 32 | Element index |

## Verification
A wrong residue in the first stage gives a modulo result that is too large or has the wrong upper bits. A dropped forced bit 31 or a misapplied increment shows as a magic quotient that is off by a large amount or by one. Each of these faults shows on out_index exactly two cycles after the request that triggered it. A valid bit lost or duplicated in either stage shows on out_valid in that same cycle, and the stage-level assertions flag it one cycle earlier. Because the random stream mixes all modes back to back, any cross-talk between adjacent requests also shows in the cycle the later request emerges.

// File: rtl/attr_div_pkg.sv
package attr_div_pkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_MOD   = 2'd1,
    MODE_SHR   = 2'd2,
    MODE_MAGIC = 2'd3
  } idx_mode_e;

  // Largest selector that still names a supported odd factor (9 = 2*4+1).
  localparam int unsigned ODD_SEL_MAX = 4;
  localparam int unsigned ODD_W       = 5;
  localparam int unsigned REM_W       = 4;

  // Odd factor picked by the flags field; out-of-range selectors fall to 1.
  function automatic logic [ODD_W-1:0] odd_of(input logic [2:0] sel);
    if (sel <= 3'(ODD_SEL_MAX)) return ODD_W'({sel, 1'b1});
    return ODD_W'(1);
  endfunction

  // Residue selector index: out-of-range selectors map to slot 0 (factor 1).
  function automatic logic [2:0] slot_of(input logic [2:0] sel);
    if (sel <= 3'(ODD_SEL_MAX)) return sel;
    return 3'd0;
  endfunction

endpackage

// File: rtl/attr_div_residue.sv
module attr_div_residue #(
  parameter int unsigned IDX_W = 32,
  parameter int unsigned ODD   = 3
) (
  input  logic [IDX_W-1:0]                  value,
  output logic [attr_div_pkg::REM_W-1:0]    rem
);
  import attr_div_pkg::*;

  localparam int unsigned ACC_W = REM_W + 1;

  logic [ACC_W-1:0] acc;

  // Bit-serial long division by a small odd constant, unrolled MSB first.
  always_comb begin
    acc = '0;
    for (int b = IDX_W - 1; b >= 0; b--) begin
      acc = {acc[ACC_W-2:0], value[b]};
      if (acc >= ACC_W'(ODD)) acc = acc - ACC_W'(ODD);
    end
    rem = acc[REM_W-1:0];
  end

endmodule

// File: rtl/attr_div_front.sv
module attr_div_front #(
  parameter int unsigned IDX_W = 32,
  parameter int unsigned SH_W  = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [IDX_W-1:0]                  in_index,
  input  attr_div_pkg::idx_mode_e           in_mode,
  input  logic [SH_W-1:0]                   in_shift,
  input  logic [IDX_W-1:0]                  in_magic,
  input  logic [2:0]                        in_flags,
  output logic                              s1_valid,
  output attr_div_pkg::idx_mode_e           s1_mode,
  output logic [SH_W-1:0]                   s1_shift,
  output logic [IDX_W-1:0]                  s1_val,
  output logic [attr_div_pkg::REM_W-1:0]    s1_rem,
  output logic [attr_div_pkg::ODD_W-1:0]    s1_odd,
  output logic [IDX_W-1:0]                  s1_low
);
  import attr_div_pkg::*;

  localparam int unsigned NSLOT  = ODD_SEL_MAX + 1;
  localparam int unsigned PROD_W = 2 * IDX_W;

  // Named internal events for the checks.
  logic               rd_apply;
  logic [IDX_W-1:0]   shifted;
  logic [IDX_W-1:0]   mul_in;
  logic [IDX_W-1:0]   mul_k;
  logic [PROD_W-1:0]  prod;
  logic [IDX_W-1:0]   mag_hi;
  logic [IDX_W-1:0]   low_mask;
  logic [REM_W-1:0]   res [NSLOT];
  logic [REM_W-1:0]   rem_sel;
  logic [IDX_W-1:0]   val_nxt;

  assign shifted  = in_index >> in_shift;
  assign low_mask = ~({IDX_W{1'b1}} << in_shift);

  // Slot 0 is factor 1: its residue is always zero.
  assign res[0] = '0;
  for (genvar g = 1; g < NSLOT; g++) begin : g_res
    attr_div_residue #(.IDX_W(IDX_W), .ODD(2 * g + 1)) u_res (
      .value (shifted),
      .rem   (res[g])
    );
  end

  assign rem_sel = res[slot_of(in_flags)];

  // Reciprocal multiply: forced top bit, optional saturating increment.
  assign rd_apply = (in_flags == 3'd1);
  assign mul_in   = (rd_apply && (in_index != {IDX_W{1'b1}})) ? in_index + 1'b1 : in_index;
  assign mul_k    = in_magic | {1'b1, {(IDX_W-1){1'b0}}};
  assign prod     = PROD_W'(mul_in) * PROD_W'(mul_k);
  assign mag_hi   = prod[PROD_W-1:IDX_W];

  assign val_nxt  = (in_mode == MODE_MAGIC) ? mag_hi : in_index;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mode  <= MODE_PASS;
      s1_shift <= '0;
      s1_val   <= '0;
      s1_rem   <= '0;
      s1_odd   <= ODD_W'(1);
      s1_low   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_mode  <= in_mode;
        s1_shift <= in_shift;
        s1_val   <= val_nxt;
        s1_rem   <= rem_sel;
        s1_odd   <= odd_of(in_flags);
        s1_low   <= in_index & low_mask;
      end
    end
  end

  // R8: first stage carries the strobe exactly one cycle.
  a_r8_stage1_valid: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid == $past(in_valid));

  // R5: with the top multiplier bit forced, the high product is at least index/2.
  a_r5_magic_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == MODE_MAGIC && !rd_apply) |=> (s1_val >= ($past(in_index) >> 1)));

  // R6: the high product never exceeds the (possibly incremented) index.
  a_r6_magic_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == MODE_MAGIC) |=> (s1_val <= $past(mul_in)));

  // R2: stored residue lies below the stored odd factor.
  a_r2_rem_range: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mode == MODE_MOD) |-> (REM_W'(s1_rem) < s1_odd));

endmodule

// File: rtl/attr_div_back.sv
module attr_div_back #(
  parameter int unsigned IDX_W = 32,
  parameter int unsigned SH_W  = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              s1_valid,
  input  attr_div_pkg::idx_mode_e           s1_mode,
  input  logic [SH_W-1:0]                   s1_shift,
  input  logic [IDX_W-1:0]                  s1_val,
  input  logic [attr_div_pkg::REM_W-1:0]    s1_rem,
  input  logic [attr_div_pkg::ODD_W-1:0]    s1_odd,
  input  logic [IDX_W-1:0]                  s1_low,
  output logic                              out_valid,
  output logic [IDX_W-1:0]                  out_index
);
  import attr_div_pkg::*;

  localparam int unsigned WIDE_W = 2 * IDX_W;

  logic [IDX_W-1:0]  mod_res;
  logic [IDX_W-1:0]  res_nxt;
  logic [WIDE_W-1:0] mod_bound;

  assign mod_res   = (IDX_W'(s1_rem) << s1_shift) | s1_low;
  assign mod_bound = WIDE_W'(s1_odd) << s1_shift;

  always_comb begin
    unique case (s1_mode)
      MODE_PASS: res_nxt = s1_val;
      MODE_MOD:  res_nxt = mod_res;
      default:   res_nxt = s1_val >> s1_shift;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_index <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_index <= res_nxt;
    end
  end

  // R8: second stage carries the strobe exactly one cycle.
  a_r8_stage2_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_valid));

  // R3: modulo result stays below the full divisor.
  a_r3_mod_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mode == MODE_MOD) |=> (WIDE_W'(out_index) < $past(mod_bound)));

endmodule

// File: rtl/attr_index_divider.sv
module attr_index_divider #(
  parameter int unsigned IDX_W = 32,
  parameter int unsigned SH_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  in_index,
  input  logic [1:0]        in_mode,
  input  logic [SH_W-1:0]   in_shift,
  input  logic [IDX_W-1:0]  in_magic,
  input  logic [2:0]        in_flags,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_index
);
  import attr_div_pkg::*;

  idx_mode_e          mode_in;
  logic               s1_valid;
  idx_mode_e          s1_mode;
  logic [SH_W-1:0]    s1_shift;
  logic [IDX_W-1:0]   s1_val;
  logic [REM_W-1:0]   s1_rem;
  logic [ODD_W-1:0]   s1_odd;
  logic [IDX_W-1:0]   s1_low;

  assign mode_in = idx_mode_e'(in_mode);

  attr_div_front #(.IDX_W(IDX_W), .SH_W(SH_W)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_index (in_index),
    .in_mode  (mode_in),
    .in_shift (in_shift),
    .in_magic (in_magic),
    .in_flags (in_flags),
    .s1_valid (s1_valid),
    .s1_mode  (s1_mode),
    .s1_shift (s1_shift),
    .s1_val   (s1_val),
    .s1_rem   (s1_rem),
    .s1_odd   (s1_odd),
    .s1_low   (s1_low)
  );

  attr_div_back #(.IDX_W(IDX_W), .SH_W(SH_W)) u_back (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_mode   (s1_mode),
    .s1_shift  (s1_shift),
    .s1_val    (s1_val),
    .s1_rem    (s1_rem),
    .s1_odd    (s1_odd),
    .s1_low    (s1_low),
    .out_valid (out_valid),
    .out_index (out_index)
  );

  // R1: pass mode returns the index from two cycles earlier.
  a_r1_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid, 2) && $past(in_mode, 2) == 2'd0) |-> (out_index == $past(in_index, 2)));

  // R4: shift mode returns the earlier index shifted by the earlier amount.
  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid, 2) && $past(in_mode, 2) == 2'd2)
      |-> (out_index == ($past(in_index, 2) >> $past(in_shift, 2))));

  // R9: no result strobe while held in reset.
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

// File: tb/attr_index_divider_tb_top.sv
module attr_index_divider_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_index;
  logic [1:0]  in_mode;
  logic [4:0]  in_shift;
  logic [31:0] in_magic;
  logic [2:0]  in_flags;
  logic        out_valid;
  logic [31:0] out_index;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // Expectation pipeline (two slots for the two-cycle latency).
  bit          p0_v, p1_v;
  logic [31:0] p0_x, p1_x;
  string       p0_t, p1_t;

  always #2.5 clk = ~clk;

  attr_index_divider dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_index  (in_index),
    .in_mode   (in_mode),
    .in_shift  (in_shift),
    .in_magic  (in_magic),
    .in_flags  (in_flags),
    .out_valid (out_valid),
    .out_index (out_index)
  );

  // Reference model written with plain division and remainder.
  function automatic logic [31:0] ref_model(input logic [1:0] md, input logic [4:0] sh,
                                            input logic [31:0] mg, input logic [2:0] fl,
                                            input logic [31:0] x);
    longint unsigned d, k, xi, q;
    case (md)
      2'd0: return x;
      2'd1: begin
        d = (fl <= 3'd4) ? (2 * longint'(fl) + 1) : 1;
        d = d * (longint'(1) << sh);
        return 32'(longint'(x) % d);
      end
      2'd2: return 32'(longint'(x) / (longint'(1) << sh));
      default: begin
        k  = longint'(mg) | 64'h8000_0000;
        xi = longint'(x);
        if (fl == 3'd1 && x != 32'hFFFF_FFFF) xi = xi + 1;
        q  = (xi * k) / 64'h1_0000_0000;
        return 32'(q / (longint'(1) << sh));
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] md, input logic [2:0] fl);
    case (md)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R4";
      default: return (fl == 3'd1) ? "R7" : "R6";
    endcase
  endfunction

  task automatic check_out();
    n_checks++;
    if (out_valid !== p1_v) begin
      n_fails++;
      $display("FAIL R8 out_valid actual=%0b expected=%0b", out_valid, p1_v);
    end
    if (p1_v) begin
      n_checks++;
      if (out_index !== p1_x) begin
        n_fails++;
        $display("FAIL %s out_index actual=%08h expected=%08h", p1_t, out_index, p1_x);
      end
    end
  endtask

  // One cycle: check the result due now, then present the next request.
  task automatic step(input bit v, input logic [1:0] md, input logic [4:0] sh,
                      input logic [31:0] mg, input logic [2:0] fl, input logic [31:0] x,
                      input logic [31:0] exp_x, input string tg);
    @(negedge clk);
    check_out();
    p1_v = p0_v; p1_x = p0_x; p1_t = p0_t;
    p0_v = v;    p0_x = exp_x; p0_t = tg;
    in_valid = v; in_mode = md; in_shift = sh; in_magic = mg; in_flags = fl; in_index = x;
  endtask

  task automatic req(input logic [1:0] md, input logic [4:0] sh, input logic [31:0] mg,
                     input logic [2:0] fl, input logic [31:0] x);
    step(1'b1, md, sh, mg, fl, x, ref_model(md, sh, mg, fl, x), tag_of(md, fl));
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 5'd0, 32'd0, 3'd0, 32'd0, 32'd0, "R8");
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    rst_n = 1'b0; in_valid = 1'b0; in_index = '0; in_mode = '0;
    in_shift = '0; in_magic = '0; in_flags = '0;
    p0_v = 0; p1_v = 0; p0_x = 0; p1_x = 0; p0_t = "R8"; p1_t = "R8";
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R9 out_valid in reset actual=%0b expected=0", out_valid);
    end
    rst_n = 1'b1;

    // Directed: pass-through of extremes (R1).
    req(2'd0, 5'd7, 32'h1234, 3'd1, 32'hFFFF_FFFF);
    req(2'd0, 5'd0, 32'h0, 3'd0, 32'h0);
    // Directed modulo (R2, R3): each odd factor, big shift, out-of-range selector.
    req(2'd1, 5'd3, 32'h0, 3'd4, 32'd70);
    req(2'd1, 5'd0, 32'h0, 3'd1, 32'hFFFF_FFFF);
    req(2'd1, 5'd2, 32'h0, 3'd2, 32'd1234567);
    req(2'd1, 5'd31, 32'h0, 3'd3, 32'hFFFF_FFFF);
    req(2'd1, 5'd5, 32'h0, 3'd6, 32'hDEAD_BEEF);
    req(2'd1, 5'd0, 32'h0, 3'd0, 32'h8765_4321);
    // Directed shift (R4): zero and maximum shift.
    req(2'd2, 5'd0, 32'h0, 3'd0, 32'hCAFE_F00D);
    req(2'd2, 5'd31, 32'h0, 3'd0, 32'hFFFF_FFFF);
    // Divide by 3 via magic constant, true quotient expected (R6, R7).
    for (int i = 0; i < 6; i++) begin
      logic [31:0] xv;
      xv = (i == 5) ? 32'hFFFF_FFF0 : 32'(i * 977 + 5);
      step(1'b1, 2'd3, 5'd1, 32'hAAAA_AAAA, 3'd1, xv, xv / 3, "R7");
    end
    // Same constant with bit 31 cleared must behave identically (R5).
    step(1'b1, 2'd3, 5'd1, 32'h2AAA_AAAA, 3'd1, 32'd100, 32'd33, "R5");
    // Divide by 7 via magic constant (R7).
    step(1'b1, 2'd3, 5'd2, 32'h9249_2492, 3'd1, 32'd1000, 32'd142, "R7");
    // Saturating increment at the top index (R7) and no increment for flags 0 (R6).
    req(2'd3, 5'd0, 32'hFFFF_FFFF, 3'd1, 32'hFFFF_FFFF);
    req(2'd3, 5'd0, 32'h0, 3'd0, 32'hFFFF_FFFF);
    req(2'd3, 5'd3, 32'h1234_5678, 3'd5, 32'd987654);
    // Gap then back-to-back (R8).
    idle();
    req(2'd0, 5'd0, 32'h0, 3'd0, 32'd11);
    idle();
    idle();

    // Constrained random stream over all modes.
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] xv;
      logic [1:0]  md;
      logic [4:0]  sh;
      logic [2:0]  fl;
      bit          v;
      xv = $urandom();
      if (($urandom() % 8) == 0) xv = 32'hFFFF_FFFF - ($urandom() % 3);
      md = 2'($urandom());
      sh = 5'($urandom());
      fl = 3'($urandom());
      v  = (($urandom() % 5) != 0);
      if (v) req(md, sh, $urandom(), fl, xv);
      else   idle();
    end
    idle();
    idle();
    idle();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule